// File: doc/BRIEF.md
# Smartcard Character Receiver with Convention Detection

This block takes the single, half-duplex data line of a contact smartcard and turns it into bytes. The line is oversampled with a fixed number of system clocks per elementary time unit (ETU, 16 by default). Each bit is decided by a majority of three samples taken around the middle of its ETU. A falling edge on the idle line opens a character: one start bit, eight data bits and one even-parity bit. Received bytes leave on a valid/ready stream.

Software can arm an initial-character check before the card's answer to reset. The next character is then compared with the two legal opening patterns, and the matching one fixes the data convention for later characters. In the inverse convention each data bit on the line is complemented and the byte arrives most significant bit first. In character mode, errors are signalled back to the card: a parity failure, a bad opening character or an optional overrun pulls the line low for one ETU in the guard time. A count of consecutive error signals is compared with a programmable limit. In block mode, characters are 11 ETU long and the line is never pulled.

Top module: `scr_rx`

## Requirements
- R1: After reset, rx_valid, io_pull_low, parity_err, ts_bad, nack_limit_hit, ts_armed and conv_inverse are all 0, so the convention is direct.
- R2: In direct convention, the eight bits after the start bit carry the byte least significant bit first, with a line high meaning 1. The ninth bit makes the count of ones over the nine bits even. A correct character appears once on rx_data with rx_valid.
- R3: While ts_armed is 1, a first character whose nine line levels after the start bit read (bit 1 first) 1,1,0,1,1,1,0,0,1 selects direct convention and delivers 0x3B. The levels 1,1,0,0,0,0,0,0,1 select inverse convention and deliver 0x3F. Either one clears ts_armed. A pulse on ts_arm sets ts_armed.
- R4: While armed, any other character gives a one-cycle ts_bad pulse, delivers no byte and leaves ts_armed at 1. In character mode with cfg_auto_nack set, it also pulls the line.
- R5: In inverse convention, a line low means 1 and the first data bit is the byte's bit 7. Parity is even over the logical (complemented) values.
- R6: In character mode with cfg_auto_nack=1, a parity failure drives io_pull_low during ETU 10.5 to 11.5 after the start edge, for at most one ETU. The byte is not delivered and parity_err stays 0.
- R7: With cfg_auto_nack=0, a parity failure delivers the byte and gives a one-cycle parity_err pulse, with no pull.
- R8: While rx_valid=1 and rx_ready=0, rx_valid and rx_data hold. A character that completes in that state is dropped.
- R9: In character mode with cfg_ovf_nack=1, a correct character that is dropped under R8 pulls the line in the same window as R6.
- R10: Every line pull adds one to a saturating count, and a correct character that is delivered clears it. nack_limit_hit is 1 while the count is at least cfg_nack_limit, and it is always 0 when the limit is 0.
- R11: With cfg_block_mode=1, characters last 11 ETU and may come back to back. io_pull_low stays 0 and parity failures are reported as in R7.
- R12: A one-clock glitch at a bit centre does not change the decided bit.
- R13: A low pulse shorter than half an ETU is not taken as a start bit, and no byte results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, OSR cycles per ETU |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_line | input | 1 | Card data line as seen by the receiver |
| io_pull_low | output | 1 | 1 = pull the data line low (error signal) |
| cfg_block_mode | input | 1 | 1 = 11 ETU characters, no error signalling |
| cfg_auto_nack | input | 1 | 1 = signal parity and bad opening character errors on the line |
| cfg_ovf_nack | input | 1 | 1 = signal dropped characters on the line |
| cfg_nack_limit | input | NACK_W | Error-signal count limit, 0 disables the flag |
| ts_arm | input | 1 | Pulse to arm the initial-character check |
| ts_armed | output | 1 | Initial-character check is pending |
| conv_inverse | output | 1 | 1 = inverse convention in force |
| rx_valid | output | 1 | Stream valid |
| rx_ready | input | 1 | Stream ready |
| rx_data | output | 8 | Received byte |
| parity_err | output | 1 | One-cycle pulse: parity failure reported without a pull |
| ts_bad | output | 1 | One-cycle pulse: armed character was not a legal opener |
| nack_limit_hit | output | 1 | Error-signal count has reached the limit |

## Verification
With the default two-stage synchroniser, the start is seen about three clocks after the bench lowers the line. A character's byte and flags then show about 157 clocks after that falling edge, and any line pull lasts from about clock 170 to clock 186. The driver samples io_pull_low at fixed offsets of 160, 172 and 190 clocks into each character: before, inside and after the window. A monitor compares bytes with a queue at each valid/ready handshake, and counts flag pulses in the same way. Convention, armed state and the limit flag are checked only after the whole character period has passed, well clear of the cycle in which they change.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // line levels of bits 1..9 after the start bit, bit 1 in position 0
  localparam logic [8:0] OPEN_DIRECT_RAW  = 9'h13B;
  localparam logic [8:0] OPEN_INVERSE_RAW = 9'h103;
  localparam logic [7:0] OPEN_DIRECT_BYTE  = 8'h3B;
  localparam logic [7:0] OPEN_INVERSE_BYTE = 8'h3F;

  typedef struct packed {
    logic [7:0] data;
    logic       good;     // character correct (or legal opener)
    logic       perr;     // parity failure reported by flag
    logic       ts_hit;
    logic       ts_inv;
    logic       ts_fail;
    logic       nack;     // pull the line in the guard window
    logic       store;    // load the output register
  } scr_verdict_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/scr_line_sync.sv
module scr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= line_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], line_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= pipe[STAGES-1];

  assign line_s = pipe[STAGES-1];
  assign fall   = prev & ~line_s;
endmodule

// File: rtl/scr_deframer.sv
module scr_deframer
  import scr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_s,
  input  logic       fall,
  input  logic       block_mode,
  input  logic       nack_req,
  output logic       frame_done,
  output logic [8:0] raw_bits,
  output logic       pull_low
);
  localparam int SW = $clog2(OSR);
  localparam logic [SW-1:0] VOTE_T = SW'(OSR / 2 + 1);
  localparam logic [SW-1:0] HALF_T = SW'(OSR / 2);
  localparam logic [SW-1:0] LAST_T = SW'(OSR - 1);

  logic          busy;
  logic [SW-1:0] sub;
  logic [3:0]    bitn;
  logic [1:0]    hist;
  logic [8:0]    raw;
  logic          done_q;
  logic          nack_arm;
  logic          v;

  assign v = vote3(hist[1], hist[0], line_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sub      <= '0;
      bitn     <= '0;
      hist     <= 2'b11;
      raw      <= '0;
      done_q   <= 1'b0;
      nack_arm <= 1'b0;
    end else begin
      hist   <= {hist[0], line_s};
      done_q <= 1'b0;
      if (!busy) begin
        if (fall) begin
          busy     <= 1'b1;
          sub      <= SW'(1);
          bitn     <= '0;
          nack_arm <= 1'b0;
        end
      end else begin
        if (sub == LAST_T) begin
          sub  <= '0;
          bitn <= bitn + 4'd1;
        end else begin
          sub <= sub + SW'(1);
        end
        if (sub == VOTE_T) begin
          if (bitn == 4'd0 && v) busy <= 1'b0;          // false start
          else if (bitn >= 4'd1 && bitn <= 4'd9) raw[bitn - 4'd1] <= v;
          if (bitn == 4'd9) done_q <= 1'b1;
          if (block_mode && bitn == 4'd10) busy <= 1'b0;
        end
        if (!block_mode && bitn == 4'd11 && sub == HALF_T) busy <= 1'b0;
        if (done_q) nack_arm <= nack_req;
      end
    end
  end

  assign frame_done = done_q;
  assign raw_bits   = raw;
  assign pull_low   = busy & nack_arm &
                      ((bitn == 4'd10 && sub >= HALF_T) || (bitn == 4'd11 && sub < HALF_T));
endmodule

// File: rtl/scr_judge.sv
module scr_judge
  import scr_pkg::*;
(
  input  logic [8:0]   raw,
  input  logic         inverse,
  input  logic         armed,
  input  logic         block_mode,
  input  logic         auto_nack,
  input  logic         ovf_nack,
  input  logic         out_busy,
  output scr_verdict_t verdict
);
  logic [7:0] dec;
  logic       par_ok, can_nack, hit_d, hit_i, deliver, overflow, err_nack;

  always_comb begin
    for (int i = 0; i < 8; i++) dec[7 - i] = ~raw[i];
    if (!inverse) dec = raw[7:0];
  end

  assign par_ok   = ((^raw) == inverse);
  assign can_nack = ~block_mode;
  assign hit_d    = (raw == OPEN_DIRECT_RAW);
  assign hit_i    = (raw == OPEN_INVERSE_RAW);

  always_comb begin
    verdict         = '0;
    verdict.ts_hit  = armed & (hit_d | hit_i);
    verdict.ts_inv  = hit_i;
    verdict.ts_fail = armed & ~(hit_d | hit_i);
    verdict.good    = armed ? (hit_d | hit_i) : par_ok;
    verdict.perr    = ~armed & ~par_ok & ~(can_nack & auto_nack);
    verdict.data    = armed ? (hit_i ? OPEN_INVERSE_BYTE : OPEN_DIRECT_BYTE) : dec;
    err_nack        = can_nack & auto_nack & (armed ? verdict.ts_fail : ~par_ok);
    deliver         = verdict.good | verdict.perr;
    overflow        = deliver & out_busy;
    verdict.store   = deliver & ~out_busy;
    verdict.nack    = err_nack | (overflow & can_nack & ovf_nack);
  end
endmodule

// File: rtl/scr_nack_count.sv
module scr_nack_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != MAXV)  cnt <= cnt + W'(1);

  assign hit = (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/scr_rx.sv
module scr_rx
  import scr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int NACK_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_line,
  output logic              io_pull_low,
  input  logic              cfg_block_mode,
  input  logic              cfg_auto_nack,
  input  logic              cfg_ovf_nack,
  input  logic [NACK_W-1:0] cfg_nack_limit,
  input  logic              ts_arm,
  output logic              ts_armed,
  output logic              conv_inverse,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [7:0]        rx_data,
  output logic              parity_err,
  output logic              ts_bad,
  output logic              nack_limit_hit
);
  logic         line_s, fall, frame_done;
  logic [8:0]   raw_bits;
  scr_verdict_t verdict;

  scr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(io_line), .line_s(line_s), .fall(fall)
  );

  scr_deframer #(.OSR(OSR)) u_deframe (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall),
    .block_mode(cfg_block_mode), .nack_req(verdict.nack),
    .frame_done(frame_done), .raw_bits(raw_bits), .pull_low(io_pull_low)
  );

  scr_judge u_judge (
    .raw(raw_bits), .inverse(conv_inverse), .armed(ts_armed),
    .block_mode(cfg_block_mode), .auto_nack(cfg_auto_nack), .ovf_nack(cfg_ovf_nack),
    .out_busy(rx_valid & ~rx_ready), .verdict(verdict)
  );

  scr_nack_count #(.W(NACK_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .inc(frame_done & verdict.nack),
    .clr(frame_done & verdict.store & verdict.good),
    .limit(cfg_nack_limit), .hit(nack_limit_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_armed     <= 1'b0;
      conv_inverse <= 1'b0;
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      parity_err   <= 1'b0;
      ts_bad       <= 1'b0;
    end else begin
      if (ts_arm) ts_armed <= 1'b1;
      else if (frame_done && verdict.ts_hit) ts_armed <= 1'b0;
      if (frame_done && verdict.ts_hit) conv_inverse <= verdict.ts_inv;
      ts_bad     <= frame_done & verdict.ts_fail;
      parity_err <= frame_done & verdict.perr;
      if (frame_done && verdict.store) begin
        rx_valid <= 1'b1;
        rx_data  <= verdict.data;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scr_rx_checker.sv
module scr_rx_checker #(
  parameter int OSR    = 16,
  parameter int NACK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_pull_low,
  input logic              cfg_block_mode,
  input logic [NACK_W-1:0] cfg_nack_limit,
  input logic              ts_armed,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [7:0]        rx_data,
  input logic              parity_err,
  input logic              ts_bad,
  input logic              nack_limit_hit
);
  localparam int RW = $clog2(OSR) + 2;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           run <= '0;
    else if (io_pull_low) run <= run + RW'(1);
    else                  run <= '0;

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));          // R8
  AST_BLOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_block_mode |-> !io_pull_low);                                  // R11
  AST_BADTS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ts_bad |-> ts_armed);                                              // R4
  AST_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_nack_limit == '0 |-> !nack_limit_hit);                         // R10
  AST_PULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(OSR));                                                  // R6
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(parity_err && ts_bad));                                          // R7
endmodule

bind scr_rx scr_rx_checker #(.OSR(OSR), .NACK_W(NACK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_pull_low(io_pull_low), .cfg_block_mode(cfg_block_mode),
  .cfg_nack_limit(cfg_nack_limit), .ts_armed(ts_armed), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .parity_err(parity_err), .ts_bad(ts_bad),
  .nack_limit_hit(nack_limit_hit)
);

// File: tb/scr_rx_test.sv
module scr_rx_test;
  localparam int OSR = 16;

  logic       clk = 1'b0, rst_n = 1'b0, io_line = 1'b1;
  logic       cfg_block_mode = 1'b0, cfg_auto_nack = 1'b1, cfg_ovf_nack = 1'b0;
  logic [3:0] cfg_nack_limit = 4'd2;
  logic       ts_arm = 1'b0, rx_ready = 1'b1;
  logic       io_pull_low, ts_armed, conv_inverse, rx_valid, parity_err, ts_bad, nack_limit_hit;
  logic [7:0] rx_data;

  int checks = 0, failures = 0, perr_n = 0, tsbad_n = 0, cycles = 0;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  scr_rx uut (
    .clk(clk), .rst_n(rst_n), .io_line(io_line), .io_pull_low(io_pull_low),
    .cfg_block_mode(cfg_block_mode), .cfg_auto_nack(cfg_auto_nack), .cfg_ovf_nack(cfg_ovf_nack),
    .cfg_nack_limit(cfg_nack_limit), .ts_arm(ts_arm), .ts_armed(ts_armed),
    .conv_inverse(conv_inverse), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .parity_err(parity_err), .ts_bad(ts_bad), .nack_limit_hit(nack_limit_hit)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] enc_dir(input logic [7:0] b);
    return {^b, b};
  endfunction

  function automatic logic [8:0] enc_inv(input logic [7:0] b);
    logic [8:0] r;
    for (int i = 0; i < 8; i++) r[i] = ~b[7 - i];
    r[8] = ~(^b);
    return r;
  endfunction

  task automatic expect_byte(input int b, input string req);
    exp_q.push_back(b);
    tag_q.push_back(req);
  endtask

  task automatic send_char(input logic [8:0] raw, input int guard, input logic exp_nack,
                           input int glitch_bit, input string req);
    for (int c = 0; c < (10 + guard) * OSR; c++) begin
      int   b;
      logic lvl;
      @(negedge clk);
      b   = c / OSR;
      lvl = (b == 0) ? 1'b0 : (b <= 9) ? raw[b - 1] : 1'b1;
      if (b == glitch_bit && (c % OSR) == OSR / 2) lvl = ~lvl;
      io_line = lvl;
      if (c == 160) chk(!io_pull_low, req, "pull before window", io_pull_low, 0);
      if (c == 172) chk(io_pull_low == exp_nack, req, "pull in window", io_pull_low, exp_nack);
      if (c == 190) chk(!io_pull_low, req, "pull after window", io_pull_low, 0);
    end
  endtask

  task automatic arm;
    @(posedge clk); #1 ts_arm = 1'b1;
    @(posedge clk); #1 ts_arm = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (parity_err) perr_n++;
      if (ts_bad) tsbad_n++;
      if (rx_valid && rx_ready) begin
        if (exp_q.size() == 0) chk(0, "R2", "unexpected byte", rx_data, 0);
        else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rx_data == e[7:0], t, "byte", rx_data, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    chk(0, "R1", "watchdog expired", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0, t0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rx_valid && !io_pull_low && !parity_err && !ts_bad, "R1", "outputs", rx_valid, 0);
    chk(!ts_armed && !conv_inverse && !nack_limit_hit, "R1", "state", {ts_armed, conv_inverse}, 0);

    // R2 direct reception
    expect_byte(8'hA5, "R2"); send_char(enc_dir(8'hA5), 2, 0, -1, "R2");
    expect_byte(8'h00, "R2"); send_char(enc_dir(8'h00), 2, 0, -1, "R2");
    expect_byte(8'hFF, "R2"); send_char(enc_dir(8'hFF), 2, 0, -1, "R2");

    // R3 direct opener
    arm;
    chk(ts_armed, "R3", "armed after pulse", ts_armed, 1);
    expect_byte(8'h3B, "R3"); send_char(9'h13B, 2, 0, -1, "R3");
    chk(!ts_armed && !conv_inverse, "R3", "direct opener", {ts_armed, conv_inverse}, 0);

    // R4 bad opener
    arm;
    t0 = tsbad_n;
    send_char(enc_dir(8'h55), 2, 1, -1, "R4");
    chk(tsbad_n == t0 + 1, "R4", "ts_bad pulses", tsbad_n - t0, 1);
    chk(ts_armed, "R4", "still armed", ts_armed, 1);

    // R3 inverse opener
    expect_byte(8'h3F, "R3"); send_char(9'h103, 2, 0, -1, "R3");
    chk(!ts_armed && conv_inverse, "R3", "inverse opener", {ts_armed, conv_inverse}, 1);

    // R5 inverse data
    expect_byte(8'h5A, "R5"); send_char(enc_inv(8'h5A), 2, 0, -1, "R5");
    expect_byte(8'h81, "R5"); send_char(enc_inv(8'h81), 2, 0, -1, "R5");

    // R6 auto error signal, R10 count with limit 2
    p0 = perr_n;
    send_char(enc_inv(8'h12) ^ 9'h100, 2, 1, -1, "R6");
    chk(!nack_limit_hit, "R10", "below limit", nack_limit_hit, 0);
    send_char(enc_inv(8'h34) ^ 9'h100, 2, 1, -1, "R6");
    chk(nack_limit_hit, "R10", "limit reached", nack_limit_hit, 1);
    chk(perr_n == p0, "R6", "no parity flag", perr_n - p0, 0);
    expect_byte(8'h56, "R10"); send_char(enc_inv(8'h56), 2, 0, -1, "R10");
    chk(!nack_limit_hit, "R10", "cleared by good char", nack_limit_hit, 0);

    // R7 flag instead of error signal
    cfg_auto_nack = 1'b0;
    expect_byte(8'h77, "R7"); send_char(enc_inv(8'h77) ^ 9'h100, 2, 0, -1, "R7");
    chk(perr_n == p0 + 1, "R7", "parity flag", perr_n - p0, 1);

    // R8 / R9 back-pressure and overrun
    cfg_ovf_nack = 1'b1;
    @(posedge clk); #1 rx_ready = 1'b0;
    expect_byte(8'h11, "R8"); send_char(enc_inv(8'h11), 2, 0, -1, "R8");
    chk(rx_valid && rx_data == 8'h11, "R8", "held byte", rx_data, 8'h11);
    send_char(enc_inv(8'h22), 2, 1, -1, "R9");
    chk(rx_valid && rx_data == 8'h11, "R8", "still held", rx_data, 8'h11);
    @(posedge clk); #1 rx_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !rx_valid, "R8", "drained, overrun dropped", exp_q.size(), 0);
    cfg_nack_limit = 4'd1;
    @(negedge clk);
    chk(nack_limit_hit, "R10", "overrun counted", nack_limit_hit, 1);
    cfg_nack_limit = 4'd0;
    @(negedge clk);
    chk(!nack_limit_hit, "R10", "limit zero", nack_limit_hit, 0);

    // R12 glitch at bit centre
    expect_byte(8'h3C, "R12"); send_char(enc_inv(8'h3C), 2, 0, 3, "R12");
    expect_byte(8'hC3, "R12"); send_char(enc_inv(8'hC3), 2, 0, 9, "R12");

    // R13 short low pulse
    @(negedge clk) io_line = 1'b0;
    repeat (4) @(negedge clk);
    io_line = 1'b1;
    repeat (220) @(negedge clk);
    chk(!rx_valid && exp_q.size() == 0, "R13", "no byte from glitch", rx_valid, 0);
    expect_byte(8'h99, "R13"); send_char(enc_inv(8'h99), 2, 0, -1, "R13");

    // R11 block mode
    cfg_block_mode = 1'b1; cfg_auto_nack = 1'b1;
    p0 = perr_n;
    expect_byte(8'h44, "R11"); send_char(enc_inv(8'h44) ^ 9'h100, 1, 0, -1, "R11");
    chk(perr_n == p0 + 1, "R11", "parity flag in block mode", perr_n - p0, 1);
    expect_byte(8'h01, "R11"); send_char(enc_inv(8'h01), 1, 0, -1, "R11");
    expect_byte(8'h02, "R11"); send_char(enc_inv(8'h02), 1, 0, -1, "R11");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all expected bytes seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule